// File: doc/BRIEF.md
# Age-Ordered Multi-Class Issue Selector

This block decides which ready instructions leave the scheduling window each cycle. Ready instructions sit in one pool per operation class. Each class feeds its own group of functional units. Every entry carries a 16-bit sequence number, a class index and a thread number. Inside a pool, the entry with the oldest sequence number is that pool's head.

A second ordering ranks the class heads by age. Grant slot 0 goes to the oldest head whose class has a free unit. Slot 1 goes to the next-oldest head, and so on, up to the issue width. When a head is granted, it leaves its pool. On the next cycle that class competes again with its next-oldest entry.

Instructions that must not run speculatively enter their pool in a held state. They are not selectable until the commit side names their sequence number. A squash for one thread removes that thread's entries that are younger than a given sequence number, held entries included.

Top module: `isel_issue_top`

## Requirements
- R1: After reset, every grant slot reports invalid, and all pools are empty.
- R2: Within a class, the eligible entry with the oldest sequence number is granted first. Age is computed modulo 2^16: a is older than b when the 16-bit difference a-b has its top bit set.
- R3: Granted instructions are ordered by age across classes. Grant slot 0 holds the oldest granted instruction, and each higher valid slot holds a younger one than the slot below it.
- R4: A cycle grants at most ISSUE_W instructions and at most one per class. Valid grants fill the slots from slot 0 upward with no gaps.
- R5: A class whose fu_free bit is 0 at the selecting edge gets no grant in that cycle. Selection moves on to the next-oldest head among the classes that are free.
- R6: Grants are registered. An insert presented at clock edge N can be granted at edge N+1 at the earliest, and appears on the grant outputs after that edge.
- R7: A granted entry leaves its pool, and it is never granted again.
- R8: An insert with ins_nonspec=1 is held and is never granted. A rel_valid pulse with a matching rel_seq makes it eligible from the following edge onward. A release naming no held entry has no effect.
- R9: A squash (sq_valid=1) removes every entry of thread sq_tid whose sequence number is younger than sq_seq. Held entries are removed too. An entry that the squash removes is not granted at the squash edge. An insert at the same edge that the squash matches is discarded.
- R10: An insert is discarded when its class pool already holds SLOTS entries at that edge, or when ins_cls is NCLS or greater.
- R11: A squash does not remove entries of another thread, and it does not remove entries of its own thread that are not younger than sq_seq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert an instruction this cycle |
| ins_seq | input | 16 | Sequence number of the insert |
| ins_cls | input | CLS_W (2) | Operation class of the insert |
| ins_tid | input | TID_W (1) | Thread of the insert |
| ins_nonspec | input | 1 | Insert in the held state until released |
| fu_free | input | NCLS (3) | Per class: a functional unit can accept an instruction |
| rel_valid | input | 1 | Commit releases a held instruction |
| rel_seq | input | 16 | Sequence number being released |
| sq_valid | input | 1 | Squash request |
| sq_tid | input | TID_W (1) | Thread being squashed |
| sq_seq | input | 16 | Entries younger than this are removed |
| gnt_valid | output | ISSUE_W (2) | Per grant slot: slot holds a grant |
| gnt_seq | output | ISSUE_W*16 (32) | Sequence number per slot, slot k at bits [16k+15:16k] |
| gnt_cls | output | ISSUE_W*CLS_W (4) | Class per slot |
| gnt_tid | output | ISSUE_W*TID_W (2) | Thread per slot |

## Verification
A pool whose age order is wrong shows at the ports the first time two entries of one class are both eligible. The younger one is granted while the older one waits, and this shows on the grant outputs one edge after selection. A lost held flag, or a squash that misses an entry, shows as a grant that should not exist. A drop at a full pool that fails shows as an extra grant when the pool drains. The reference model compares every grant slot after every edge, so each such fault is caught in the cycle where it first changes a grant.

// File: rtl/isel_pkg.sv
package isel_pkg;
    localparam int SEQ_W = 16;

    typedef logic [SEQ_W-1:0] seq_t;

    // a precedes b in program order under modulo-2^SEQ_W arithmetic
    function automatic logic seq_before(seq_t a, seq_t b);
        seq_t diff;
        diff = a - b;
        return diff[SEQ_W-1];
    endfunction
endpackage

// File: rtl/isel_class_pool.sv
module isel_class_pool
    import isel_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int TID_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  seq_t             wr_seq,
    input  logic [TID_W-1:0] wr_tid,
    input  logic             wr_held,
    input  logic             pop_en,
    input  logic             sq_valid,
    input  logic [TID_W-1:0] sq_tid,
    input  seq_t             sq_seq,
    input  logic             rel_valid,
    input  seq_t             rel_seq,
    output logic             head_valid,
    output seq_t             head_seq,
    output logic [TID_W-1:0] head_tid,
    output logic             full
);
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    typedef struct packed {
        logic             vld;
        logic             held;
        seq_t             seq;
        logic [TID_W-1:0] tid;
    } slot_t;

    typedef struct packed {
        slot_t [SLOTS-1:0] slot;
    } pool_t;

    pool_t            st_d, st_q;
    logic [SLOTS-1:0] doomed;
    logic [SLOTS-1:0] eligible;
    logic [IDX_W-1:0] head_idx;
    logic [IDX_W-1:0] free_idx;
    logic             free_found;

    // squash victims and selectable entries
    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            doomed[i]   = st_q.slot[i].vld && sq_valid &&
                          (st_q.slot[i].tid == sq_tid) &&
                          seq_before(sq_seq, st_q.slot[i].seq);
            eligible[i] = st_q.slot[i].vld && !st_q.slot[i].held && !doomed[i];
        end
    end

    // oldest eligible entry
    always_comb begin
        head_valid = 1'b0;
        head_idx   = '0;
        head_seq   = '0;
        head_tid   = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (eligible[i] && (!head_valid || seq_before(st_q.slot[i].seq, head_seq))) begin
                head_valid = 1'b1;
                head_idx   = IDX_W'(i);
                head_seq   = st_q.slot[i].seq;
                head_tid   = st_q.slot[i].tid;
            end
        end
    end

    // lowest empty slot
    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!st_q.slot[i].vld) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    assign full = !free_found;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < SLOTS; i++) begin
            if (doomed[i] || (pop_en && head_valid && head_idx == IDX_W'(i))) begin
                st_d.slot[i].vld = 1'b0;
            end
            if (rel_valid && st_q.slot[i].vld && st_q.slot[i].held &&
                st_q.slot[i].seq == rel_seq) begin
                st_d.slot[i].held = 1'b0;
            end
        end
        if (wr_en && free_found) begin
            st_d.slot[free_idx].vld  = 1'b1;
            st_d.slot[free_idx].held = wr_held;
            st_d.slot[free_idx].seq  = wr_seq;
            st_d.slot[free_idx].tid  = wr_tid;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/isel_age_pick.sv
module isel_age_pick
    import isel_pkg::*;
#(
    parameter int NCLS    = 3,
    parameter int ISSUE_W = 2,
    parameter int CLS_W   = 2
) (
    input  logic [NCLS-1:0]                head_valid,
    input  seq_t [NCLS-1:0]                head_seq,
    input  logic [NCLS-1:0]                fu_free,
    output logic [ISSUE_W-1:0]             pick_valid,
    output logic [ISSUE_W-1:0][CLS_W-1:0]  pick_cls,
    output logic [NCLS-1:0]                pop
);
    logic [NCLS-1:0]  taken;
    logic             best_v;
    logic [CLS_W-1:0] best_c;
    seq_t             best_s;

    // repeated oldest-head search; each pass excludes classes already chosen
    always_comb begin
        taken      = '0;
        pick_valid = '0;
        pick_cls   = '0;
        best_v     = 1'b0;
        best_c     = '0;
        best_s     = '0;
        for (int k = 0; k < ISSUE_W; k++) begin
            best_v = 1'b0;
            best_c = '0;
            best_s = '0;
            for (int c = 0; c < NCLS; c++) begin
                if (head_valid[c] && fu_free[c] && !taken[c] &&
                    (!best_v || seq_before(head_seq[c], best_s))) begin
                    best_v = 1'b1;
                    best_c = CLS_W'(c);
                    best_s = head_seq[c];
                end
            end
            pick_valid[k] = best_v;
            pick_cls[k]   = best_c;
            if (best_v) begin
                taken[best_c] = 1'b1;
            end
        end
        pop = taken;
    end
endmodule

// File: rtl/isel_issue_top.sv
module isel_issue_top
    import isel_pkg::*;
#(
    parameter int NCLS    = 3,
    parameter int SLOTS   = 4,
    parameter int ISSUE_W = 2,
    parameter int TID_W   = 1,
    localparam int CLS_W  = (NCLS > 1) ? $clog2(NCLS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ins_valid,
    input  logic [SEQ_W-1:0]           ins_seq,
    input  logic [CLS_W-1:0]           ins_cls,
    input  logic [TID_W-1:0]           ins_tid,
    input  logic                       ins_nonspec,
    input  logic [NCLS-1:0]            fu_free,
    input  logic                       rel_valid,
    input  logic [SEQ_W-1:0]           rel_seq,
    input  logic                       sq_valid,
    input  logic [TID_W-1:0]           sq_tid,
    input  logic [SEQ_W-1:0]           sq_seq,
    output logic [ISSUE_W-1:0]         gnt_valid,
    output logic [ISSUE_W*SEQ_W-1:0]   gnt_seq,
    output logic [ISSUE_W*CLS_W-1:0]   gnt_cls,
    output logic [ISSUE_W*TID_W-1:0]   gnt_tid
);
    typedef struct packed {
        logic [ISSUE_W-1:0]             vld;
        logic [ISSUE_W-1:0][SEQ_W-1:0]  seq;
        logic [ISSUE_W-1:0][CLS_W-1:0]  cls;
        logic [ISSUE_W-1:0][TID_W-1:0]  tid;
    } gnt_t;

    logic [NCLS-1:0]                head_valid;
    seq_t [NCLS-1:0]                head_seq;
    logic [NCLS-1:0][TID_W-1:0]     head_tid;
    logic [NCLS-1:0]                pool_full;
    logic [NCLS-1:0]                pop;
    logic [ISSUE_W-1:0]             pick_valid;
    logic [ISSUE_W-1:0][CLS_W-1:0]  pick_cls;
    logic                           ins_doomed;
    gnt_t                           gnt_d, gnt_q;

    assign ins_doomed = sq_valid && (ins_tid == sq_tid) && seq_before(sq_seq, ins_seq);

    for (genvar c = 0; c < NCLS; c++) begin : g_pool
        logic wr_here;
        assign wr_here = ins_valid && !ins_doomed && (ins_cls == CLS_W'(c));

        isel_class_pool #(
            .SLOTS (SLOTS),
            .TID_W (TID_W)
        ) pool_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (wr_here),
            .wr_seq     (ins_seq),
            .wr_tid     (ins_tid),
            .wr_held    (ins_nonspec),
            .pop_en     (pop[c]),
            .sq_valid   (sq_valid),
            .sq_tid     (sq_tid),
            .sq_seq     (sq_seq),
            .rel_valid  (rel_valid),
            .rel_seq    (rel_seq),
            .head_valid (head_valid[c]),
            .head_seq   (head_seq[c]),
            .head_tid   (head_tid[c]),
            .full       (pool_full[c])
        );
    end

    isel_age_pick #(
        .NCLS    (NCLS),
        .ISSUE_W (ISSUE_W),
        .CLS_W   (CLS_W)
    ) pick_i (
        .head_valid (head_valid),
        .head_seq   (head_seq),
        .fu_free    (fu_free),
        .pick_valid (pick_valid),
        .pick_cls   (pick_cls),
        .pop        (pop)
    );

    always_comb begin
        gnt_d = '0;
        for (int k = 0; k < ISSUE_W; k++) begin
            if (pick_valid[k]) begin
                gnt_d.vld[k] = 1'b1;
                gnt_d.seq[k] = head_seq[pick_cls[k]];
                gnt_d.cls[k] = pick_cls[k];
                gnt_d.tid[k] = head_tid[pick_cls[k]];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_q <= '0;
        end else begin
            gnt_q <= gnt_d;
        end
    end

    assign gnt_valid = gnt_q.vld;
    assign gnt_seq   = gnt_q.seq;
    assign gnt_cls   = gnt_q.cls;
    assign gnt_tid   = gnt_q.tid;
endmodule

// File: rtl/isel_issue_chk.sv
module isel_issue_chk
    import isel_pkg::*;
#(
    parameter int NCLS    = 3,
    parameter int ISSUE_W = 2,
    parameter int TID_W   = 1,
    parameter int CLS_W   = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NCLS-1:0]            fu_free,
    input logic                       sq_valid,
    input logic [TID_W-1:0]           sq_tid,
    input logic [SEQ_W-1:0]           sq_seq,
    input logic [ISSUE_W-1:0]         gnt_valid,
    input logic [ISSUE_W*SEQ_W-1:0]   gnt_seq,
    input logic [ISSUE_W*CLS_W-1:0]   gnt_cls,
    input logic [ISSUE_W*TID_W-1:0]   gnt_tid
);
    logic [NCLS-1:0]            fu_prev;
    logic                       sq_v_prev;
    logic [TID_W-1:0]           sq_tid_prev;
    seq_t                       sq_seq_prev;
    logic [ISSUE_W-1:0]         gv_prev;
    logic [ISSUE_W*SEQ_W-1:0]   gs_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fu_prev     <= '0;
            sq_v_prev   <= 1'b0;
            sq_tid_prev <= '0;
            sq_seq_prev <= '0;
            gv_prev     <= '0;
            gs_prev     <= '0;
        end else begin
            fu_prev     <= fu_free;
            sq_v_prev   <= sq_valid;
            sq_tid_prev <= sq_tid;
            sq_seq_prev <= sq_seq;
            gv_prev     <= gnt_valid;
            gs_prev     <= gnt_seq;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (gnt_valid == '0));

    for (genvar k = 0; k < ISSUE_W; k++) begin : g_slot
        // R5
        busy_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_valid[k] |-> ((fu_prev >> gnt_cls[k*CLS_W +: CLS_W]) & NCLS'(1)) != '0);

        // R9
        squash_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt_valid[k] && sq_v_prev && gnt_tid[k*TID_W +: TID_W] == sq_tid_prev)
            |-> !seq_before(sq_seq_prev, gnt_seq[k*SEQ_W +: SEQ_W]));

        if (k > 0) begin : g_order
            // R3
            slot_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
                gnt_valid[k] |-> (gnt_valid[k-1] &&
                    seq_before(gnt_seq[(k-1)*SEQ_W +: SEQ_W], gnt_seq[k*SEQ_W +: SEQ_W])));
        end

        for (genvar j = 0; j < ISSUE_W; j++) begin : g_pair
            // R7
            no_regrant_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (gnt_valid[j] && gv_prev[k]) |->
                (gnt_seq[j*SEQ_W +: SEQ_W] != gs_prev[k*SEQ_W +: SEQ_W]));
            if (j > k) begin : g_uniq
                // R4
                class_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (gnt_valid[j] && gnt_valid[k]) |->
                    (gnt_cls[j*CLS_W +: CLS_W] != gnt_cls[k*CLS_W +: CLS_W]));
            end
        end
    end
endmodule

bind isel_issue_top isel_issue_chk #(
    .NCLS    (NCLS),
    .ISSUE_W (ISSUE_W),
    .TID_W   (TID_W),
    .CLS_W   (CLS_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .fu_free   (fu_free),
    .sq_valid  (sq_valid),
    .sq_tid    (sq_tid),
    .sq_seq    (sq_seq),
    .gnt_valid (gnt_valid),
    .gnt_seq   (gnt_seq),
    .gnt_cls   (gnt_cls),
    .gnt_tid   (gnt_tid)
);

// File: tb/isel_issue_tb.sv
`timescale 1ns/1ps
module isel_issue_top_tb_top;
    localparam int NCLS = 3, SLOTS = 4, IW = 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ins_valid, ins_nonspec, rel_valid, sq_valid;
    logic [15:0] ins_seq, rel_seq, sq_seq;
    logic [1:0]  ins_cls;
    logic [0:0]  ins_tid, sq_tid;
    logic [2:0]  fu_free;
    logic [1:0]  gnt_valid;
    logic [31:0] gnt_seq;
    logic [3:0]  gnt_cls;
    logic [1:0]  gnt_tid;

    always #2 clk = ~clk;

    isel_issue_top dut_i (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_seq(ins_seq),
        .ins_cls(ins_cls), .ins_tid(ins_tid), .ins_nonspec(ins_nonspec),
        .fu_free(fu_free), .rel_valid(rel_valid), .rel_seq(rel_seq),
        .sq_valid(sq_valid), .sq_tid(sq_tid), .sq_seq(sq_seq),
        .gnt_valid(gnt_valid), .gnt_seq(gnt_seq), .gnt_cls(gnt_cls), .gnt_tid(gnt_tid)
    );

    typedef struct {
        int seq;
        int cls;
        int tid;
        bit held;
    } ent_t;

    ent_t  pool[$];
    bit    exp_v[IW];
    int    exp_seq[IW], exp_cls[IW], exp_tid[IW];
    int    checks = 0, errors = 0;
    int    c2_grants = 0, t1_grants = 0;
    string tag = "R1";

    function automatic bit older(int a, int b);
        logic [15:0] d;
        d = 16'(a) - 16'(b);
        return d[15];
    endfunction

    function automatic bit killed(int seq, int tid);
        return sq_valid && (tid == int'(sq_tid)) && older(int'(sq_seq), seq);
    endfunction

    task automatic model_step();
        ent_t nxt[$];
        int   cnt[NCLS];
        int   hidx[NCLS];
        bit   used[NCLS];
        for (int c = 0; c < NCLS; c++) begin cnt[c] = 0; hidx[c] = -1; used[c] = 0; end
        for (int k = 0; k < IW; k++) begin
            exp_v[k] = 0; exp_seq[k] = 0; exp_cls[k] = 0; exp_tid[k] = 0;
        end
        foreach (pool[i]) cnt[pool[i].cls]++;
        foreach (pool[i]) begin
            if (!pool[i].held && !killed(pool[i].seq, pool[i].tid) && fu_free[pool[i].cls]) begin
                if (hidx[pool[i].cls] < 0 || older(pool[i].seq, pool[hidx[pool[i].cls]].seq))
                    hidx[pool[i].cls] = i;
            end
        end
        for (int k = 0; k < IW; k++) begin
            int best;
            best = -1;
            for (int c = 0; c < NCLS; c++) begin
                if (hidx[c] >= 0 && !used[c] &&
                    (best < 0 || older(pool[hidx[c]].seq, pool[hidx[best]].seq))) best = c;
            end
            if (best >= 0) begin
                used[best] = 1;
                exp_v[k]   = 1;
                exp_seq[k] = pool[hidx[best]].seq;
                exp_cls[k] = best;
                exp_tid[k] = pool[hidx[best]].tid;
            end
        end
        foreach (pool[i]) begin
            ent_t e;
            e = pool[i];
            if (killed(e.seq, e.tid)) continue;
            if (used[e.cls] && hidx[e.cls] == i) continue;
            if (rel_valid && e.held && e.seq == int'(rel_seq)) e.held = 0;
            nxt.push_back(e);
        end
        if (ins_valid && int'(ins_cls) < NCLS && cnt[ins_cls] < SLOTS &&
            !killed(int'(ins_seq), int'(ins_tid))) begin
            ent_t e;
            e.seq = int'(ins_seq); e.cls = int'(ins_cls); e.tid = int'(ins_tid); e.held = ins_nonspec;
            nxt.push_back(e);
        end
        pool = nxt;
    endtask

    task automatic compare();
        for (int k = 0; k < IW; k++) begin
            int gs, gc, gt;
            bit gv;
            gv = gnt_valid[k];
            gs = int'(gnt_seq[k*16 +: 16]);
            gc = int'(gnt_cls[k*2 +: 2]);
            gt = int'(gnt_tid[k]);
            checks++;
            if (gv != exp_v[k] || (exp_v[k] && (gs != exp_seq[k] || gc != exp_cls[k] || gt != exp_tid[k]))) begin
                errors++;
                $display("FAIL %s slot %0d: got v=%0d seq=%h cls=%0d tid=%0d, expected v=%0d seq=%h cls=%0d tid=%0d",
                         tag, k, gv, gs, gc, gt, exp_v[k], exp_seq[k], exp_cls[k], exp_tid[k]);
            end
            if (gv && gc == 2) c2_grants++;
            if (gv && gt == 1) t1_grants++;
        end
    endtask

    task automatic check_eq(string req, int got, int want);
        checks++;
        if (got != want) begin
            errors++;
            $display("FAIL %s: got %0d, expected %0d", req, got, want);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        ins_valid = 0; ins_nonspec = 0; rel_valid = 0; sq_valid = 0;
    endtask

    task automatic put(int seq, int cls, int tid, bit ns);
        ins_valid = 1; ins_seq = 16'(seq); ins_cls = 2'(cls); ins_tid = 1'(tid); ins_nonspec = ns;
        cycle();
    endtask

    task automatic drain(int n, logic [2:0] free);
        fu_free = free;
        repeat (n) cycle();
    endtask

    initial begin
        int seq_ctr;
        int held_list[$];
        rst_n = 0; ins_valid = 0; ins_nonspec = 0; rel_valid = 0; sq_valid = 0;
        ins_seq = 0; ins_cls = 0; ins_tid = 0; rel_seq = 0; sq_seq = 0; sq_tid = 0; fu_free = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: reset state
        check_eq("R1 reset grants", int'(gnt_valid), 0);
        fu_free = 3'b111;
        cycle();
        check_eq("R1 empty after reset", int'(gnt_valid), 0);

        // R2: oldest first within a class
        tag = "R2"; fu_free = 0;
        put(10, 0, 0, 0); put(5, 0, 0, 0); put(7, 0, 0, 0);
        drain(4, 3'b001);

        // R2: wraparound ordering
        tag = "R2 wrap"; fu_free = 0;
        put('hFFFE, 1, 0, 0); put('h0001, 1, 0, 0); put('hFFFF, 1, 0, 0);
        drain(4, 3'b010);

        // R3/R4/R7: cross-class age order, width cap, no repeat grants
        tag = "R3/R4/R7"; fu_free = 0;
        put(20, 0, 0, 0); put(23, 0, 0, 0); put(21, 1, 0, 0);
        put(25, 1, 0, 0); put(22, 2, 0, 0); put(24, 2, 0, 0);
        drain(5, 3'b111);

        // R5: busy class skipped
        tag = "R5"; fu_free = 0;
        put(30, 0, 0, 0); put(31, 1, 0, 0); put(32, 2, 0, 0);
        drain(1, 3'b110);
        drain(3, 3'b001);

        // R6: registered grant latency
        tag = "R6"; fu_free = 3'b111;
        put(70, 0, 0, 0);
        drain(3, 3'b111);

        // R8: held until released
        tag = "R8"; fu_free = 3'b001;
        put(40, 0, 0, 0 + 1); put(41, 0, 0, 0);
        drain(3, 3'b001);
        rel_valid = 1; rel_seq = 16'd99; cycle();
        rel_valid = 1; rel_seq = 16'd40; cycle();
        drain(3, 3'b001);

        // R9/R11: squash by thread and age
        tag = "R9/R11"; fu_free = 0;
        put(50, 0, 0, 0); put(52, 1, 0, 0); put(54, 2, 0, 0);
        put(51, 0, 1, 0); put(53, 1, 1, 0); put(55, 2, 0, 1);
        t1_grants = 0;
        sq_valid = 1; sq_tid = 0; sq_seq = 16'd52;
        ins_valid = 1; ins_seq = 16'd56; ins_cls = 1; ins_tid = 0;
        cycle();
        drain(5, 3'b111);
        check_eq("R11 other thread survives squash", t1_grants, 2);

        // R10: full pool and bad class dropped
        tag = "R10"; fu_free = 0;
        for (int s = 60; s < 65; s++) put(s, 2, 0, 0);
        put(65, 3, 0, 0);
        c2_grants = 0;
        drain(7, 3'b111);
        check_eq("R10 class 2 drain count", c2_grants, SLOTS);

        // mixed traffic with wraparound
        tag = "R2/R3/R5/R8/R9 mixed";
        seq_ctr = 'hFFC0;
        for (int n = 0; n < 160; n++) begin
            fu_free = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 3) != 0) begin
                seq_ctr = (seq_ctr + int'($urandom_range(1, 2))) & 'hFFFF;
                ins_valid = 1; ins_seq = 16'(seq_ctr);
                ins_cls = 2'($urandom_range(0, 3)); ins_tid = 1'($urandom_range(0, 1));
                ins_nonspec = ($urandom_range(0, 4) == 0);
                if (ins_nonspec) held_list.push_back(seq_ctr);
            end
            if (held_list.size() > 0 && $urandom_range(0, 3) == 0) begin
                rel_valid = 1; rel_seq = 16'(held_list.pop_front());
            end
            if ($urandom_range(0, 19) == 0) begin
                sq_valid = 1; sq_tid = 1'($urandom_range(0, 1));
                sq_seq = 16'((seq_ctr - int'($urandom_range(0, 6))) & 'hFFFF);
            end
            cycle();
        end
        drain(8, 3'b111);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog: got no finish, expected finish before limit");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule